// File: doc/BRIEF.md
# Dual-Store L1 Allocation Controller

This block holds the tag and control logic of a first-level data cache split into two stores whose contents never overlap: a large direct-mapped store and a small fully associative store with least-recently-used replacement. Every request probes both stores in the same cycle. A hit is answered on the next cycle, and the block stays in the store where it was found.

On a miss, the controller asks an external reuse predictor for a verdict in the same cycle, using the requesting PC and the block address. It then raises a refill request toward the next level and stalls. When the refill is acknowledged, the block goes into the large store if it was predicted temporal, or into the small store if it was predicted nontemporal. Any block displaced by the fill is reported for one cycle, together with the PC that allocated it and whether it was referenced again during its stay, so that the predictor can be trained.

The store sizes and the block size are parameters. Stores take the same allocation path as loads, because the cache allocates on writes. Only tags are modelled.

Top module: `dual_store_alloc_ctrl`

## Requirements
- R1: A block address is never resident in both stores. Every access reports a hit in at most one store.
- R2: A request accepted while its block is resident produces, one cycle later, `resp_valid_o=1` and `resp_hit_o=1`, with `resp_small_o` naming the holding store (0 = large, 1 = small). Repeated hits never move the block.
- R3: On a miss the verdict `pred_nt_i` is sampled in the cycle of acceptance. The value 0 places the block in the large store at index = low set bits of the block address. The value 1 places it in the small store.
- R4: A fill into the large store displaces the block held at the same index, if that entry is valid.
- R5: A fill into the small store uses the lowest-numbered empty way if one exists. Otherwise it displaces the least recently touched way, where a way is touched by a fill or a hit.
- R6: A displacement raises `evict_valid_o` for exactly one cycle, in the cycle where the miss response appears. It carries the victim block address, the PC of the request that allocated it, and `evict_temporal_o`=1 if and only if the victim was hit at least once after being allocated.
- R7: A write (`req_we_i`=1) that misses follows the same placement as a read, and every response echoes the request's write flag on `resp_we_o`.
- R8: After a miss is accepted, `req_ready_o` is 0 and `fill_req_o` is 1 with `fill_addr_o` = the block address (the byte address without its offset bits). Requests offered during this time are ignored. The cycle after `fill_ack_i` is seen, `resp_valid_o`=1, `resp_hit_o`=0, and `req_ready_o` returns to 1.
- R9: After reset both stores are empty, `req_ready_o`=1, and no response, refill or eviction is signalled.
- R10: `pred_query_o` is 1 exactly in the cycle a missing request is accepted, with `pred_pc_o` and `pred_blk_o` giving that request's PC and block address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_addr_i | input | ADDR_W | Byte address |
| req_pc_i | input | PC_W | PC of the memory instruction |
| req_we_i | input | 1 | 1 = store, 0 = load |
| resp_valid_o | output | 1 | Access completed |
| resp_hit_o | output | 1 | Completed access was a hit |
| resp_small_o | output | 1 | Block now held in the small store |
| resp_we_o | output | 1 | Write flag of the completed access |
| fill_req_o | output | 1 | Refill outstanding |
| fill_addr_o | output | BLK_W | Block address being refilled |
| fill_ack_i | input | 1 | Next level delivers the block |
| pred_query_o | output | 1 | Predictor query strobe |
| pred_pc_o | output | PC_W | PC for the query |
| pred_blk_o | output | BLK_W | Block address for the query |
| pred_nt_i | input | 1 | Verdict: 1 = nontemporal |
| evict_valid_o | output | 1 | Victim report strobe |
| evict_blk_o | output | BLK_W | Victim block address |
| evict_pc_o | output | PC_W | PC that allocated the victim |
| evict_temporal_o | output | 1 | Victim was reused during its stay |

## Verification
The bound checker watches every cycle for a simultaneous hit in both stores. It also checks the hit response and the store it names, the stall and refill request that follow a miss, the release after the acknowledge, and that an eviction report lasts one cycle and comes only with a miss completion. Which way the small store gives up, which PC and reuse flag a victim carries, that placement follows the verdict, and that requests offered during a stall leave no trace are shown only by the bench. It runs long address sweeps on a reduced configuration (8 sets, 4 ways) and compares each result against a reference computed in the bench.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  typedef enum logic {ST_IDLE, ST_FILL} dsa_state_e;
endpackage

// File: rtl/dsa_dm_store.sv
module dsa_dm_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 19,
  parameter int PC_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  input  logic             touch_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [PC_W-1:0]  fill_pc_i,
  output logic             vic_valid_o,
  output logic [TAG_W-1:0] vic_tag_o,
  output logic [PC_W-1:0]  vic_pc_o,
  output logic             vic_reused_o
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]  valid_q, reused_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PC_W-1:0]  pc_q  [SETS];

  assign hit_o        = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  assign vic_valid_o  = valid_q[fill_idx_i];
  assign vic_tag_o    = tag_q[fill_idx_i];
  assign vic_pc_o     = pc_q[fill_idx_i];
  assign vic_reused_o = reused_q[fill_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      reused_q <= '0;
    end else if (fill_i) begin
      valid_q[fill_idx_i]  <= 1'b1;
      reused_q[fill_idx_i] <= 1'b0;
    end else if (touch_i) begin
      reused_q[lk_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      tag_q[fill_idx_i] <= fill_tag_i;
      pc_q[fill_idx_i]  <= fill_pc_i;
    end
  end
endmodule

// File: rtl/dsa_fa_store.sv
module dsa_fa_store #(
  parameter int WAYS  = 32,
  parameter int BLK_W = 27,
  parameter int PC_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] lk_blk_i,
  output logic             hit_o,
  input  logic             touch_i,
  input  logic             fill_i,
  input  logic [BLK_W-1:0] fill_blk_i,
  input  logic [PC_W-1:0]  fill_pc_i,
  output logic             vic_valid_o,
  output logic [BLK_W-1:0] vic_blk_o,
  output logic [PC_W-1:0]  vic_pc_o,
  output logic             vic_reused_o
);
  localparam int AGE_W = $clog2(WAYS);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

  logic [WAYS-1:0]  valid_q, reused_q, hit_vec;
  logic [BLK_W-1:0] blk_q [WAYS];
  logic [PC_W-1:0]  pc_q  [WAYS];
  logic [AGE_W-1:0] age_q [WAYS];
  logic [AGE_W-1:0] hit_way, vic_way, touch_way, ref_age;
  logic             vic_found;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[w] && (blk_q[w] == lk_blk_i);
  end
  assign hit_o = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = AGE_W'(w);
  end

  // empty way first (lowest index), else the oldest way
  always_comb begin
    vic_way   = '0;
    vic_found = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (!valid_q[w] && !vic_found) begin
        vic_way   = AGE_W'(w);
        vic_found = 1'b1;
      end
    if (!vic_found)
      for (int w = 0; w < WAYS; w++)
        if (age_q[w] == AGE_MAX) vic_way = AGE_W'(w);
  end

  assign vic_valid_o  = valid_q[vic_way];
  assign vic_blk_o    = blk_q[vic_way];
  assign vic_pc_o     = pc_q[vic_way];
  assign vic_reused_o = reused_q[vic_way];

  assign touch_way = fill_i ? vic_way : hit_way;
  // ages of valid ways stay a permutation of 0..n-1
  assign ref_age   = valid_q[touch_way] ? age_q[touch_way] : AGE_MAX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      reused_q <= '0;
      for (int w = 0; w < WAYS; w++) age_q[w] <= '0;
    end else begin
      if (fill_i || touch_i)
        for (int w = 0; w < WAYS; w++)
          if (touch_way == AGE_W'(w)) age_q[w] <= '0;
          else if (valid_q[w] && age_q[w] < ref_age) age_q[w] <= age_q[w] + 1'b1;
      if (fill_i) begin
        valid_q[vic_way]  <= 1'b1;
        reused_q[vic_way] <= 1'b0;
      end else if (touch_i) begin
        reused_q[hit_way] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      blk_q[vic_way] <= fill_blk_i;
      pc_q[vic_way]  <= fill_pc_i;
    end
  end
endmodule

// File: rtl/dual_store_alloc_ctrl.sv
module dual_store_alloc_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int PC_W      = 32,
  parameter int BLK_BYTES = 32,
  parameter int LG_BYTES  = 8192,
  parameter int SM_BYTES  = 1024,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int BLK_W    = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [PC_W-1:0]   req_pc_i,
  input  logic              req_we_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_small_o,
  output logic              resp_we_o,
  output logic              fill_req_o,
  output logic [BLK_W-1:0]  fill_addr_o,
  input  logic              fill_ack_i,
  output logic              pred_query_o,
  output logic [PC_W-1:0]   pred_pc_o,
  output logic [BLK_W-1:0]  pred_blk_o,
  input  logic              pred_nt_i,
  output logic              evict_valid_o,
  output logic [BLK_W-1:0]  evict_blk_o,
  output logic [PC_W-1:0]   evict_pc_o,
  output logic              evict_temporal_o
);
  import dsa_pkg::*;

  localparam int SETS  = LG_BYTES / BLK_BYTES;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = BLK_W - IDX_W;
  localparam int WAYS  = SM_BYTES / BLK_BYTES;

  dsa_state_e       state_q;
  logic [BLK_W-1:0] req_blk, miss_blk_q, sm_vic_blk;
  logic [PC_W-1:0]  miss_pc_q, lg_vic_pc, sm_vic_pc;
  logic [TAG_W-1:0] lg_vic_tag;
  logic             miss_nt_q, miss_we_q;
  logic             accept, hit_lg, hit_sm, hit_any, fill_done;
  logic             lg_vic_valid, lg_vic_reused, sm_vic_valid, sm_vic_reused;
  logic             unused_offset;

  assign req_blk       = req_addr_i[ADDR_W-1:OFF_W];
  assign unused_offset = ^req_addr_i[OFF_W-1:0];
  assign req_ready_o   = (state_q == ST_IDLE);
  assign accept        = req_valid_i && req_ready_o;
  assign hit_any       = hit_lg || hit_sm;
  assign fill_done     = (state_q == ST_FILL) && fill_ack_i;

  assign pred_query_o  = accept && !hit_any;
  assign pred_pc_o     = req_pc_i;
  assign pred_blk_o    = req_blk;
  assign fill_req_o    = (state_q == ST_FILL);
  assign fill_addr_o   = miss_blk_q;

  dsa_dm_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) i_lg (
    .clk_i, .rst_ni,
    .lk_idx_i    (req_blk[IDX_W-1:0]),
    .lk_tag_i    (req_blk[BLK_W-1:IDX_W]),
    .hit_o       (hit_lg),
    .touch_i     (accept && hit_lg),
    .fill_i      (fill_done && !miss_nt_q),
    .fill_idx_i  (miss_blk_q[IDX_W-1:0]),
    .fill_tag_i  (miss_blk_q[BLK_W-1:IDX_W]),
    .fill_pc_i   (miss_pc_q),
    .vic_valid_o (lg_vic_valid),
    .vic_tag_o   (lg_vic_tag),
    .vic_pc_o    (lg_vic_pc),
    .vic_reused_o(lg_vic_reused)
  );

  dsa_fa_store #(.WAYS(WAYS), .BLK_W(BLK_W), .PC_W(PC_W)) i_sm (
    .clk_i, .rst_ni,
    .lk_blk_i    (req_blk),
    .hit_o       (hit_sm),
    .touch_i     (accept && hit_sm),
    .fill_i      (fill_done && miss_nt_q),
    .fill_blk_i  (miss_blk_q),
    .fill_pc_i   (miss_pc_q),
    .vic_valid_o (sm_vic_valid),
    .vic_blk_o   (sm_vic_blk),
    .vic_pc_o    (sm_vic_pc),
    .vic_reused_o(sm_vic_reused)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      miss_blk_q <= '0;
      miss_pc_q  <= '0;
      miss_nt_q  <= 1'b0;
      miss_we_q  <= 1'b0;
    end else if (accept && !hit_any) begin
      state_q    <= ST_FILL;
      miss_blk_q <= req_blk;
      miss_pc_q  <= req_pc_i;
      miss_nt_q  <= pred_nt_i;
      miss_we_q  <= req_we_i;
    end else if (fill_done) begin
      state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o     <= 1'b0;
      resp_hit_o       <= 1'b0;
      resp_small_o     <= 1'b0;
      resp_we_o        <= 1'b0;
      evict_valid_o    <= 1'b0;
      evict_blk_o      <= '0;
      evict_pc_o       <= '0;
      evict_temporal_o <= 1'b0;
    end else begin
      resp_valid_o     <= (accept && hit_any) || fill_done;
      resp_hit_o       <= accept && hit_any;
      resp_small_o     <= fill_done ? miss_nt_q : hit_sm;
      resp_we_o        <= fill_done ? miss_we_q : req_we_i;
      evict_valid_o    <= fill_done && (miss_nt_q ? sm_vic_valid : lg_vic_valid);
      evict_blk_o      <= miss_nt_q ? sm_vic_blk : {lg_vic_tag, miss_blk_q[IDX_W-1:0]};
      evict_pc_o       <= miss_nt_q ? sm_vic_pc : lg_vic_pc;
      evict_temporal_o <= miss_nt_q ? sm_vic_reused : lg_vic_reused;
    end
  end
endmodule

// File: rtl/dsa_checker.sv
module dsa_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic hit_lg,
  input logic hit_sm,
  input logic resp_valid_o,
  input logic resp_hit_o,
  input logic resp_small_o,
  input logic fill_req_o,
  input logic fill_ack_i,
  input logic evict_valid_o
);
  logic acc_hit, acc_miss;
  assign acc_hit  = req_valid_i && req_ready_o && (hit_lg || hit_sm);
  assign acc_miss = req_valid_i && req_ready_o && !hit_lg && !hit_sm;

  assert_disjoint_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_lg && hit_sm));

  assert_hit_resp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hit |=> resp_valid_o && resp_hit_o && (resp_small_o == $past(hit_sm)));

  assert_miss_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_miss |=> !req_ready_o && fill_req_o && !resp_valid_o);

  assert_fill_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && fill_ack_i) |=> req_ready_o && resp_valid_o && !resp_hit_o);

  assert_evict_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |=> !evict_valid_o);

  assert_evict_on_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> resp_valid_o && !resp_hit_o);
endmodule

bind dual_store_alloc_ctrl dsa_checker i_dsa_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .hit_lg       (hit_lg),
  .hit_sm       (hit_sm),
  .resp_valid_o (resp_valid_o),
  .resp_hit_o   (resp_hit_o),
  .resp_small_o (resp_small_o),
  .fill_req_o   (fill_req_o),
  .fill_ack_i   (fill_ack_i),
  .evict_valid_o(evict_valid_o)
);

// File: tb/test_dual_store_alloc_ctrl.sv
module test_dual_store_alloc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16, PC_W = 16, BLK_BYTES = 16;
  localparam int LG_BYTES = 128, SM_BYTES = 64;
  localparam int OFF_W = 4, BLK_W = 12, SETS = 8, IDX_W = 3, WAYS = 4;

  logic clk = 0, rst_ni = 0;
  logic req_valid_i = 0, req_we_i = 0, fill_ack_i = 0, pred_nt_i = 0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [PC_W-1:0]   req_pc_i = '0;
  logic req_ready_o, resp_valid_o, resp_hit_o, resp_small_o, resp_we_o;
  logic fill_req_o, pred_query_o, evict_valid_o, evict_temporal_o;
  logic [BLK_W-1:0] fill_addr_o, pred_blk_o, evict_blk_o;
  logic [PC_W-1:0]  pred_pc_o, evict_pc_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_store_alloc_ctrl #(.ADDR_W(ADDR_W), .PC_W(PC_W), .BLK_BYTES(BLK_BYTES),
    .LG_BYTES(LG_BYTES), .SM_BYTES(SM_BYTES)) i_dual_store_alloc_ctrl (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_pc_i,
    .req_we_i, .resp_valid_o, .resp_hit_o, .resp_small_o, .resp_we_o,
    .fill_req_o, .fill_addr_o, .fill_ack_i, .pred_query_o, .pred_pc_o,
    .pred_blk_o, .pred_nt_i, .evict_valid_o, .evict_blk_o, .evict_pc_o,
    .evict_temporal_o);

  int n_vec = 0, n_bad = 0, now = 0;
  logic             dm_v [SETS], dm_r [SETS];
  logic [BLK_W-1:0] dm_blk [SETS];
  logic [PC_W-1:0]  dm_pc [SETS];
  logic             fa_v [WAYS], fa_r [WAYS];
  logic [BLK_W-1:0] fa_blk [WAYS];
  logic [PC_W-1:0]  fa_pc [WAYS];
  int               fa_ts [WAYS];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [BLK_W-1:0] blk, input logic [PC_W-1:0] pc,
                        input logic we, input logic nt, input logic junk);
    int idx = int'(blk[IDX_W-1:0]);
    int sw = -1, vw = -1;
    logic e_lg, ev_v, ev_t;
    logic [BLK_W-1:0] ev_blk;
    logic [PC_W-1:0] ev_pc;
    string ptag;
    now++;
    e_lg = dm_v[idx] && dm_blk[idx] == blk;
    for (int w = 0; w < WAYS; w++) if (fa_v[w] && fa_blk[w] == blk) sw = w;
    @(negedge clk);
    req_valid_i = 1; req_addr_i = {blk, 4'(now)}; req_pc_i = pc;
    req_we_i = we; pred_nt_i = nt;
    #1;
    chk("R8 ready idle", 64'(req_ready_o), 1);
    chk("R10 query", 64'(pred_query_o), 64'(!(e_lg || sw >= 0)));
    if (!(e_lg || sw >= 0)) begin
      chk("R10 pc", 64'(pred_pc_o), 64'(pc));
      chk("R10 blk", 64'(pred_blk_o), 64'(blk));
    end
    @(negedge clk);
    req_valid_i = 0;
    if (e_lg || sw >= 0) begin
      chk("R1 single store hit", 64'(e_lg && sw >= 0), 0);
      chk("R2 resp", 64'({resp_valid_o, resp_hit_o, resp_small_o}), 64'({2'b11, sw >= 0}));
      chk("R7 we echo", 64'(resp_we_o), 64'(we));
      chk("R6 no evict on hit", 64'(evict_valid_o), 0);
      if (e_lg) dm_r[idx] = 1;
      else begin fa_r[sw] = 1; fa_ts[sw] = now; end
    end else begin
      chk("R8 stall", 64'({resp_valid_o, req_ready_o, fill_req_o}), 64'(3'b001));
      chk("R8 fill addr", 64'(fill_addr_o), 64'(blk));
      if (junk) begin
        req_valid_i = 1; req_addr_i = {blk ^ 12'h5, 4'h0};
        @(negedge clk);
        req_valid_i = 0;
        chk("R8 ignored req", 64'({resp_valid_o, req_ready_o, fill_req_o}), 64'(3'b001));
      end
      fill_ack_i = 1;
      @(negedge clk);
      fill_ack_i = 0;
      ptag = we ? "R7 write alloc" : "R3 placement";
      chk(ptag, 64'({resp_valid_o, resp_hit_o, resp_small_o}), 64'({2'b10, nt}));
      chk("R7 we echo", 64'(resp_we_o), 64'(we));
      chk("R8 ready back", 64'(req_ready_o), 1);
      if (!nt) begin
        ev_v = dm_v[idx]; ev_blk = dm_blk[idx]; ev_pc = dm_pc[idx]; ev_t = dm_r[idx];
        dm_v[idx] = 1; dm_blk[idx] = blk; dm_pc[idx] = pc; dm_r[idx] = 0;
        ptag = "R4 large victim";
      end else begin
        for (int w = WAYS-1; w >= 0; w--) if (!fa_v[w]) vw = w;
        if (vw < 0) begin
          vw = 0;
          for (int w = 1; w < WAYS; w++) if (fa_ts[w] < fa_ts[vw]) vw = w;
        end
        ev_v = fa_v[vw]; ev_blk = fa_blk[vw]; ev_pc = fa_pc[vw]; ev_t = fa_r[vw];
        fa_v[vw] = 1; fa_blk[vw] = blk; fa_pc[vw] = pc; fa_r[vw] = 0; fa_ts[vw] = now;
        ptag = "R5 small victim";
      end
      chk(ptag, 64'(evict_valid_o), 64'(ev_v));
      if (ev_v) begin
        chk(ptag, 64'(evict_blk_o), 64'(ev_blk));
        chk("R6 victim pc", 64'(evict_pc_o), 64'(ev_pc));
        chk("R6 victim reuse", 64'(evict_temporal_o), 64'(ev_t));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R8: watchdog expired, actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    automatic logic [31:0] lcg = 32'h1234_5677;
    for (int i = 0; i < SETS; i++) begin dm_v[i] = 0; dm_r[i] = 0; end
    for (int w = 0; w < WAYS; w++) begin fa_v[w] = 0; fa_r[w] = 0; fa_ts[w] = 0; end
    #(CLK_PERIOD * 2 + 2);
    chk("R9 reset", 64'({req_ready_o, resp_valid_o, fill_req_o, evict_valid_o}), 64'(4'b1000));
    rst_ni = 1;
    #(CLK_PERIOD);
    chk("R9 after reset", 64'({req_ready_o, resp_valid_o, fill_req_o, evict_valid_o}), 64'(4'b1000));
    // directed: small-store LRU order, reuse flags, large-store conflict
    for (int b = 0; b < WAYS; b++) access(12'(16 + b), 16'(100 + b), 0, 1, 0);
    access(12'd16, 16'd7, 0, 0, 0);             // hit in small, stays there
    access(12'd21, 16'd200, 1, 1, 1);           // evicts blk 17
    access(12'd3, 16'd300, 0, 0, 0);
    access(12'd3, 16'd301, 1, 0, 0);
    access(12'd11, 16'd302, 0, 0, 0);           // same index, reused victim
    // sweep
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      access(12'(lcg[23:16] % 40), 16'(lcg[15:4]), lcg[29], lcg[27] & lcg[26], lcg[30] & lcg[31]);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule